// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital timing core of a dual-slope integrating converter. Every measurement cycle steps through four phases: auto-zero, signal-integrate, reference-deintegrate and zero-integrator. In each phase exactly one switch-control output to the analog front end is high. A comparator input reports which side of zero the integrator output sits on. It passes through a synchronizer and is then used twice. At the end of signal-integrate it fixes the input polarity. During deintegrate it marks the zero crossing.

The number of deintegrate clocks before the crossing is the 12-bit magnitude. It is published together with a polarity flag and an over-range flag. A run input selects back-to-back conversions or holding in auto-zero. A busy output covers the span from the start of integration until the result is published.

Top module: `dsadc_seq`

## Requirements
- R1: While the synchronous active-low reset is asserted, the sequencer sits in auto-zero (only `sw_az_o` high). `busy_o`, `mag_o`, `pos_o` and `ovr_o` read zero.
- R2: Exactly one of `sw_az_o`, `sw_int_o`, `sw_de_o`, `sw_zi_o` is high in every cycle. The phases always follow the order auto-zero, signal-integrate, deintegrate, zero-integrator, auto-zero.
- R3: Signal-integrate lasts exactly 2048 clock cycles.
- R4: With `run_i` held high, consecutive signal-integrate starts are exactly 8192 cycles apart. Auto-zero absorbs whatever time deintegrate did not use.
- R5: The comparator level (1 means above zero, a positive input) seen at the end of signal-integrate is the input polarity. It is published on `pos_o` with the result. `ref_neg_o` is high during deintegrate exactly when that polarity is positive, and is never high outside deintegrate.
- R6: If the comparator input changes level after the N-th deintegrate clock (1 ≤ N ≤ 4095), the published magnitude is N and `ovr_o` is 0. The synchronizer latency does not appear in the count.
- R7: If no crossing occurs within the first 4096 deintegrate clocks, deintegrate ends after 4097 cycles, `mag_o` reads 4095 and `ovr_o` is 1. A crossing after exactly the 4095th clock still gives a valid 4095 with `ovr_o` 0.
- R8: Zero-integrator lasts exactly 256 clock cycles.
- R9: With `run_i` low, the sequencer stays in auto-zero once the frame has ended. The result stays unchanged. Signal-integrate begins on the first clock edge after `run_i` returns high.
- R10: `busy_o` is high from the first signal-integrate cycle until the cycle in which deintegrate ends. The result outputs change only in the cycle where `busy_o` falls, which is the first zero-integrator cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| run_i | input | 1 | 1: convert continuously, 0: hold in auto-zero after the current frame |
| cmp_i | input | 1 | Asynchronous comparator level, 1 = integrator above zero |
| sw_az_o | output | 1 | Auto-zero switch control |
| sw_int_o | output | 1 | Signal-integrate switch control |
| sw_de_o | output | 1 | Deintegrate switch control |
| sw_zi_o | output | 1 | Zero-integrator switch control |
| ref_neg_o | output | 1 | Apply the negative reference during deintegrate |
| busy_o | output | 1 | Conversion in progress |
| mag_o | output | 12 | Conversion magnitude |
| pos_o | output | 1 | Result polarity, 1 = positive input |
| ovr_o | output | 1 | Over-range, the magnitude is forced to full scale |

## Verification
The zero-crossing detection and the deintegrate timeout can fall in the same cycle. This happens when the comparator flips after exactly the 4095th deintegrate clock. In that case the crossing must win and give a valid 4095 with no over-range flag. The bench's integrator model provokes this by flipping the comparator after 4095 clocks. It then repeats with 4096 and 5000 clocks, which must both give full scale with `ovr_o` set. Each result is judged by a scoreboard entry pushed when the stimulus was queued.

// File: rtl/dsadc_seq_pkg.sv
// Shared phase encoding for the dual-slope sequencer.
package dsadc_seq_pkg;
    typedef enum logic [1:0] {
        PH_AZ  = 2'd0,
        PH_INT = 2'd1,
        PH_DE  = 2'd2,
        PH_ZI  = 2'd3
    } phase_e;
endpackage

// File: rtl/dsadc_sync.sv
// Multi-flop synchronizer for the asynchronous comparator level.
// Assumes the input is quasi-static compared with the clock; resets to 0.
module dsadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // shift the raw level through the flop chain
    always_ff @(posedge clk_i) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dsadc_timer.sv
// Phase sequencer: a frame counter fixes the 8192-clock frame and a phase
// counter times integrate and zero-integrator. Deintegrate ends on de_done_i.
// Assumes INT_CLKS >= ZI_CLKS and INT + DE_MAX_LEN + ZI < FRAME_CLKS.
module dsadc_timer
    import dsadc_seq_pkg::*;
#(
    parameter int FRAME_CLKS = 8192,
    parameter int INT_CLKS   = 2048,
    parameter int ZI_CLKS    = 256,
    parameter int DE_MAX_LEN = 4097
) (
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   run_i,
    input  logic   de_done_i,
    output phase_e phase_o,
    output logic   int_last_o
);
    localparam int FW       = $clog2(FRAME_CLKS);
    localparam int PCW      = $clog2(INT_CLKS);
    localparam int AZ_START = INT_CLKS + DE_MAX_LEN + ZI_CLKS;

    phase_e         phase_q;
    logic [FW-1:0]  frame_q;
    logic [PCW-1:0] pcnt_q;

    // advance the frame position and the phase
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phase_q <= PH_AZ;
            frame_q <= FW'(AZ_START);
            pcnt_q  <= '0;
        end else begin
            unique case (phase_q)
                PH_AZ: begin
                    if (frame_q == FW'(FRAME_CLKS - 1)) begin
                        if (run_i) begin
                            frame_q <= '0;
                            pcnt_q  <= '0;
                            phase_q <= PH_INT;
                        end
                    end else begin
                        frame_q <= frame_q + FW'(1);
                    end
                end
                PH_INT: begin
                    frame_q <= frame_q + FW'(1);
                    if (pcnt_q == PCW'(INT_CLKS - 1)) begin
                        pcnt_q  <= '0;
                        phase_q <= PH_DE;
                    end else begin
                        pcnt_q <= pcnt_q + PCW'(1);
                    end
                end
                PH_DE: begin
                    frame_q <= frame_q + FW'(1);
                    if (de_done_i) begin
                        pcnt_q  <= '0;
                        phase_q <= PH_ZI;
                    end
                end
                PH_ZI: begin
                    frame_q <= frame_q + FW'(1);
                    if (pcnt_q == PCW'(ZI_CLKS - 1)) begin
                        pcnt_q  <= '0;
                        phase_q <= PH_AZ;
                    end else begin
                        pcnt_q <= pcnt_q + PCW'(1);
                    end
                end
                default: phase_q <= PH_AZ;
            endcase
        end
    end

    assign phase_o    = phase_q;
    assign int_last_o = (phase_q == PH_INT) && (pcnt_q == PCW'(INT_CLKS - 1));
endmodule

// File: rtl/dsadc_deint.sv
// Polarity latch, deintegrate counter and result registers.
// The comparator input is already synchronized; one clock of its latency is
// taken off the count. The timeout fires when the count reaches 2**MAG_W,
// and a crossing seen in that same cycle takes priority.
module dsadc_deint
    import dsadc_seq_pkg::*;
#(
    parameter int MAG_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  phase_e           phase_i,
    input  logic             int_last_i,
    input  logic             cmp_s_i,
    output logic             de_done_o,
    output logic             ref_neg_o,
    output logic [MAG_W-1:0] mag_o,
    output logic             pos_o,
    output logic             ovr_o
);
    localparam int CW     = MAG_W + 1;
    localparam int DE_MAX = 1 << MAG_W;

    logic          pol_q;
    logic [CW-1:0] dcnt_q;
    logic          crossed;
    logic          timeout;

    assign crossed   = (phase_i == PH_DE) && (cmp_s_i != pol_q);
    assign timeout   = (phase_i == PH_DE) && (dcnt_q == CW'(DE_MAX));
    assign de_done_o = crossed || timeout;
    assign ref_neg_o = (phase_i == PH_DE) && pol_q;

    // latch the polarity at integrate end and count deintegrate clocks
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pol_q  <= 1'b0;
            dcnt_q <= '0;
        end else if (int_last_i) begin
            pol_q  <= cmp_s_i;
            dcnt_q <= '0;
        end else if (phase_i == PH_DE) begin
            dcnt_q <= dcnt_q + CW'(1);
        end
    end

    // publish the result when deintegrate ends
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mag_o <= '0;
            pos_o <= 1'b0;
            ovr_o <= 1'b0;
        end else if (de_done_o) begin
            pos_o <= pol_q;
            if (crossed) begin
                mag_o <= MAG_W'(dcnt_q - CW'(1));
                ovr_o <= 1'b0;
            end else begin
                mag_o <= '1;
                ovr_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dsadc_seq.sv
// Top of the dual-slope conversion sequencer: synchronizer, phase timer and
// deintegrate/result logic. Switch outputs are decoded from the phase.
module dsadc_seq
    import dsadc_seq_pkg::*;
#(
    parameter int MAG_W      = 12,
    parameter int FRAME_CLKS = 8192,
    parameter int INT_CLKS   = 2048,
    parameter int ZI_CLKS    = 256,
    parameter int SYNC_STG   = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             cmp_i,
    output logic             sw_az_o,
    output logic             sw_int_o,
    output logic             sw_de_o,
    output logic             sw_zi_o,
    output logic             ref_neg_o,
    output logic             busy_o,
    output logic [MAG_W-1:0] mag_o,
    output logic             pos_o,
    output logic             ovr_o
);
    localparam int DE_MAX_LEN = (1 << MAG_W) + 1;

    logic   cmp_s;
    logic   de_done;
    logic   int_last;
    phase_e phase;

    dsadc_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (cmp_i),
        .q_o    (cmp_s)
    );

    dsadc_timer #(
        .FRAME_CLKS (FRAME_CLKS),
        .INT_CLKS   (INT_CLKS),
        .ZI_CLKS    (ZI_CLKS),
        .DE_MAX_LEN (DE_MAX_LEN)
    ) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (run_i),
        .de_done_i  (de_done),
        .phase_o    (phase),
        .int_last_o (int_last)
    );

    dsadc_deint #(.MAG_W(MAG_W)) u_deint (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .phase_i    (phase),
        .int_last_i (int_last),
        .cmp_s_i    (cmp_s),
        .de_done_o  (de_done),
        .ref_neg_o  (ref_neg_o),
        .mag_o      (mag_o),
        .pos_o      (pos_o),
        .ovr_o      (ovr_o)
    );

    assign sw_az_o  = (phase == PH_AZ);
    assign sw_int_o = (phase == PH_INT);
    assign sw_de_o  = (phase == PH_DE);
    assign sw_zi_o  = (phase == PH_ZI);
    assign busy_o   = sw_int_o || sw_de_o;
endmodule

// File: rtl/dsadc_seq_chk.sv
// Assertion checker for dsadc_seq, attached by bind. It observes ports only
// and keeps its own phase-length counters.
module dsadc_seq_chk #(
    parameter int MAG_W    = 12,
    parameter int INT_CLKS = 2048
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             sw_az_o,
    input logic             sw_int_o,
    input logic             sw_de_o,
    input logic             sw_zi_o,
    input logic             ref_neg_o,
    input logic             busy_o,
    input logic [MAG_W-1:0] mag_o,
    input logic             pos_o,
    input logic             ovr_o
);
    localparam int DE_MAX = 1 << MAG_W;
    localparam int LW     = MAG_W + 2;

    logic [LW-1:0] int_len_q;
    logic [LW-1:0] de_len_q;

    // count integrate and deintegrate cycles, cleared in auto-zero
    always_ff @(posedge clk_i) begin
        if (!rst_ni || sw_az_o) begin
            int_len_q <= '0;
            de_len_q  <= '0;
        end else begin
            if (sw_int_o) int_len_q <= int_len_q + LW'(1);
            if (sw_de_o)  de_len_q  <= de_len_q + LW'(1);
        end
    end

    AST_ONE_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({sw_az_o, sw_int_o, sw_de_o, sw_zi_o}) == 1); // R2
    AST_INT_AFTER_AZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sw_int_o) |-> $past(sw_az_o)); // R2
    AST_DE_AFTER_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sw_de_o) |-> $past(sw_int_o)); // R2
    AST_INT_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sw_int_o) |-> (int_len_q == LW'(INT_CLKS))); // R3
    AST_REF_IN_DE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ref_neg_o |-> sw_de_o); // R5
    AST_OVR_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovr_o |-> (mag_o == '1)); // R7
    AST_DE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sw_de_o |-> (de_len_q <= LW'(DE_MAX))); // R7
    AST_BUSY_TO_ZI: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> sw_zi_o); // R10
    AST_RESULT_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable({mag_o, pos_o, ovr_o}) |-> $fell(busy_o)); // R10
endmodule

bind dsadc_seq dsadc_seq_chk #(.MAG_W(MAG_W), .INT_CLKS(INT_CLKS)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_az_o   (sw_az_o),
    .sw_int_o  (sw_int_o),
    .sw_de_o   (sw_de_o),
    .sw_zi_o   (sw_zi_o),
    .ref_neg_o (ref_neg_o),
    .busy_o    (busy_o),
    .mag_o     (mag_o),
    .pos_o     (pos_o),
    .ovr_o     (ovr_o)
);

// File: tb/dsadc_seq_tb_top.sv
// Scoreboard bench: push_conv queues a stimulus for the integrator model and
// the expected result; the monitor pops and compares when busy falls.
module dsadc_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b1;
    logic        cmp = 1'b0;
    logic        sw_az, sw_int, sw_de, sw_zi, ref_neg, busy, pos, ovr;
    logic [11:0] mag;

    typedef struct { int n; bit p; } stim_t;
    typedef struct { int mag; bit p; bit ovr; } exp_t;
    stim_t stim_q[$];
    exp_t  exp_q[$];
    int    total = 0;
    int    bad = 0;
    bit    res_bad = 0;

    always #5 clk = ~clk;

    dsadc_seq dut_i (
        .clk_i(clk), .rst_ni(rst_n), .run_i(run), .cmp_i(cmp),
        .sw_az_o(sw_az), .sw_int_o(sw_int), .sw_de_o(sw_de), .sw_zi_o(sw_zi),
        .ref_neg_o(ref_neg), .busy_o(busy), .mag_o(mag), .pos_o(pos), .ovr_o(ovr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic push_conv(input int n, input bit p);
        exp_t e;
        stim_q.push_back('{n: n, p: p});
        e.p   = p;
        e.ovr = (n > 4095);
        e.mag = (n > 4095) ? 4095 : n;
        exp_q.push_back(e);
    endtask

    // integrator model plus phase-timing and result monitor
    stim_t      cur = '{n: 50, p: 1'b1};
    int         k = 0, int_len = 0, zi_len = 0, frame_cnt = 0;
    bit         have_rise = 0, steady = 0;
    bit         prev_int = 0, prev_busy = 0;
    logic [3:0] prev_ph = 4'b0001;
    logic [13:0] prev_res = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] ph;
            ph = {sw_zi, sw_de, sw_int, sw_az};
            if (sw_int && !prev_int) begin
                if (stim_q.size() > 0) cur = stim_q.pop_front();
                else cur = '{n: 50, p: 1'b1};
                cmp = cur.p;
                k = 0;
                check(busy == 1'b1, "R10", "busy at integrate start", busy, 1);
                if (have_rise && steady)
                    check(frame_cnt == 8192, "R4", "frame length", frame_cnt, 8192);
                have_rise = 1; steady = 1; frame_cnt = 0;
            end
            frame_cnt++;
            if (!run) steady = 0;
            if (sw_de) begin
                k++;
                if (k == 1) check(ref_neg == cur.p, "R5", "ref_neg in deintegrate", ref_neg, cur.p);
                if (k == cur.n) cmp = ~cur.p;
            end
            if (ph != prev_ph)
                check(ph == {prev_ph[2:0], prev_ph[3]}, "R2", "phase order", ph,
                      {prev_ph[2:0], prev_ph[3]});
            if (sw_int) int_len++;
            else if (int_len != 0) begin
                check(int_len == 2048, "R3", "integrate length", int_len, 2048);
                int_len = 0;
            end
            if (sw_zi) zi_len++;
            else if (zi_len != 0) begin
                check(zi_len == 256, "R8", "zero-integrator length", zi_len, 256);
                zi_len = 0;
            end
            if (prev_busy && !busy) begin
                check(sw_zi == 1'b1, "R10", "busy falls into zero-integrator", sw_zi, 1);
                if (exp_q.size() > 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(int'(mag) == e.mag, e.ovr ? "R7" : "R6", "magnitude", mag, e.mag);
                    check(ovr == e.ovr, "R7", "over-range flag", ovr, e.ovr);
                    check(pos == e.p, "R5", "polarity", pos, e.p);
                end
            end else if ({mag, pos, ovr} != prev_res) begin
                res_bad = 1;
            end
            prev_ph = ph;
        end
        prev_int  = sw_int;
        prev_busy = busy;
        prev_res  = {mag, pos, ovr};
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired: actual=%0d expected=%0d", 200000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // main sequence
    initial begin
        push_conv(100, 1'b1);   // R6 positive
        push_conv(2000, 1'b0);  // R6 negative
        push_conv(1, 1'b1);     // R6 smallest count
        push_conv(4095, 1'b1);  // R7 crossing and timeout in the same cycle
        push_conv(4096, 1'b0);  // R7 just past full scale
        push_conv(5000, 1'b1);  // R7 no crossing at all
        push_conv(3000, 1'b0);  // R6
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sw_az && !sw_int && !sw_de && !sw_zi, "R1", "reset phase",
              {sw_zi, sw_de, sw_int, sw_az}, 1);
        check(!busy && mag == 0 && !pos && !ovr, "R1", "reset result",
              {busy, mag, pos, ovr}, 0);
        rst_n = 1'b1;
        while (exp_q.size() > 0) @(negedge clk);
        run = 1'b0;
        begin
            bit saw_int;
            logic [13:0] held;
            saw_int = 0;
            held = {mag, pos, ovr};
            repeat (20000) begin
                @(negedge clk);
                if (sw_int) saw_int = 1;
            end
            check(!saw_int && sw_az, "R9", "hold in auto-zero", saw_int, 0);
            check({mag, pos, ovr} == held, "R9", "result held", {mag, pos, ovr}, held);
        end
        push_conv(777, 1'b0);   // R9 resume
        run = 1'b1;
        @(negedge clk);
        check(sw_int == 1'b1, "R9", "integrate on resume", sw_int, 1);
        while (exp_q.size() > 0) @(negedge clk);
        check(!res_bad, "R10", "result changes only at busy fall", res_bad, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule